// File: doc/BRIEF.md
# Byte-Grouped GPIO Data Port Bank

This block serves the runtime side of a general-purpose I/O bank. Its lines are split into groups of eight. Each group owns one byte-wide data port, and the ports sit at consecutive host I/O addresses starting at a base address. A separate configuration block supplies the base address, a per-line output-enable vector and a per-line GPIO-select vector. The data ports carry only two things: reads of the pin levels, and writes to the output latches. Software changes a single line by reading the group, changing one bit and writing the byte back.

Every host access completes in one cycle. A registered hit flag tells the host bus that the address fell inside the bank's window. A registered read-data byte returns the sampled pin levels.

For each line the bank produces three pad controls:
- a drive value taken from the line's latch,
- a drive enable,
- a copy of the pad level for an alternate function, used when the line is not in GPIO mode.

Only the lowest groups have a GPIO-select field. In the higher groups every line is always in GPIO mode.

Top module: `gpio_port_bank`

## Requirements
- R1: Line n belongs to group n/8 at bit n%8. Bit k of a byte written to group g lands on `pad_out[8*g+k]`.
- R2: An access hits when `io_rd` or `io_wr` is high and the offset `(io_addr - cfg_base) mod 2^ADDR_W` is below NUM_GROUPS. `io_hit` is 1 in the cycle after a hit and 0 in the cycle after any other cycle. The window therefore wraps past the top of the address space.
- R3: A read hit to group g sets `io_rdata` in the next cycle to `pad_in[8*g +: 8]` as sampled at the access. After any cycle without a read hit, `io_rdata` is 0.
- R4: A write hit replaces all eight latches of the addressed group, and the new value appears on `pad_out` in the next cycle. Writes outside the window and reads leave every latch unchanged.
- R5: `pad_oe[n]` is 1 exactly when `cfg_oe[n]` is 1 and line n is in GPIO mode.
- R6: A line in group g < SIMPLE_GROUPS is in GPIO mode only when `cfg_sel[n]` is 1. Lines in higher groups are always in GPIO mode. `alt_in[n]` equals `pad_in[n]` for a line not in GPIO mode and is 0 otherwise.
- R7: While `rst_n` is low, all latches, `io_hit` and `io_rdata` are 0.
- R8: A change of `cfg_base` moves the window starting with the next access.
- R9: A read of a line that drives its pad returns the driven level, because the pad feeds the driven value back on `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| io_hit | output | 1 | Registered window hit flag |
| cfg_base | input | ADDR_W | Window base address from configuration |
| cfg_oe | input | NUM_GROUPS*8 | Per-line output enable |
| cfg_sel | input | NUM_GROUPS*8 | Per-line GPIO select, used for the low groups only |
| pad_in | input | NUM_GROUPS*8 | Pad levels |
| pad_out | output | NUM_GROUPS*8 | Pad drive values (latches) |
| pad_oe | output | NUM_GROUPS*8 | Pad drive enables |
| alt_in | output | NUM_GROUPS*8 | Pad level routed to the alternate function |

## Verification
The bench builds the block with its default parameters: eight groups (64 lines), five groups with a GPIO-select field and a 16-bit address. This gives both kinds of group, so the select gating and the always-GPIO upper groups are both exercised.

With a 16-bit address, the bench can move the base to 0xFFFC. It then hits ports 0x0000 to 0x0003 through the wrap, and checks that offset 8 misses.

The pads are looped back as a real board would drive them. As a result, reads of output lines return the latched values and feed R9.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int LINES_PER_GROUP = 8;

  typedef logic [LINES_PER_GROUP-1:0] gbyte_t;

  // group index holding a given line
  function automatic int unsigned line_group(input int unsigned line);
    return line / LINES_PER_GROUP;
  endfunction

  // bit position of a line inside its group byte
  function automatic int unsigned line_bit(input int unsigned line);
    return line % LINES_PER_GROUP;
  endfunction

  // width needed for a group index, never below one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode #(
  parameter int ADDR_W     = 16,
  parameter int NUM_GROUPS = 8,
  parameter int GRP_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              rd,
  input  logic              wr,
  output logic              in_win,
  output logic [GRP_W-1:0]  grp,
  output logic              rd_hit,
  output logic              wr_hit
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(NUM_GROUPS);

  // modular distance from base; wraps past the top of the space
  function automatic logic [ADDR_W-1:0] port_offset(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b
  );
    return a - b;
  endfunction

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = port_offset(addr, base);
    in_win = (off < WIN_SIZE);
    grp    = off[GRP_W-1:0];
    rd_hit = rd & in_win;
    wr_hit = wr & in_win;
  end
endmodule

// File: rtl/gpb_group.sv
module gpb_group #(
  parameter int LPG     = 8,
  parameter bit HAS_SEL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [LPG-1:0] wdata,
  input  logic [LPG-1:0] cfg_oe,
  input  logic [LPG-1:0] cfg_sel,
  input  logic [LPG-1:0] pad_in,
  output logic [LPG-1:0] pad_out,
  output logic [LPG-1:0] pad_oe,
  output logic [LPG-1:0] alt_in
);
  logic [LPG-1:0] latch_q;
  logic [LPG-1:0] gpio_mode;

  // groups without a select field are permanently GPIO
  assign gpio_mode = cfg_sel | {LPG{~HAS_SEL}};

  always_ff @(posedge clk) begin
    if (!rst_n)     latch_q <= '0;
    else if (wr_en) latch_q <= wdata;
  end

  assign pad_out = latch_q;
  assign pad_oe  = cfg_oe & gpio_mode;
  assign alt_in  = pad_in & ~gpio_mode;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int ADDR_W        = 16,
  parameter int NUM_GROUPS    = 8,
  parameter int SIMPLE_GROUPS = 5,
  localparam int LPG          = gpb_pkg::LINES_PER_GROUP,
  localparam int NL           = NUM_GROUPS * LPG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [LPG-1:0]    io_wdata,
  output logic [LPG-1:0]    io_rdata,
  output logic              io_hit,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [NL-1:0]     cfg_oe,
  input  logic [NL-1:0]     cfg_sel,
  input  logic [NL-1:0]     pad_in,
  output logic [NL-1:0]     pad_out,
  output logic [NL-1:0]     pad_oe,
  output logic [NL-1:0]     alt_in
);
  localparam int GRP_W = gpb_pkg::idx_width(NUM_GROUPS);

  // named decode events, also watched by the checker
  logic             in_win;
  logic [GRP_W-1:0] hit_grp;
  logic             rd_hit;
  logic             wr_hit;
  logic [LPG-1:0]   rd_byte;

  gpb_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_GROUPS(NUM_GROUPS),
    .GRP_W     (GRP_W)
  ) u_decode (
    .addr  (io_addr),
    .base  (cfg_base),
    .rd    (io_rd),
    .wr    (io_wr),
    .in_win(in_win),
    .grp   (hit_grp),
    .rd_hit(rd_hit),
    .wr_hit(wr_hit)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic wr_en;
    assign wr_en = wr_hit && (hit_grp == GRP_W'(g));

    gpb_group #(
      .LPG    (LPG),
      .HAS_SEL(g < SIMPLE_GROUPS)
    ) u_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wdata  (io_wdata),
      .cfg_oe (cfg_oe [g*LPG +: LPG]),
      .cfg_sel(cfg_sel[g*LPG +: LPG]),
      .pad_in (pad_in [g*LPG +: LPG]),
      .pad_out(pad_out[g*LPG +: LPG]),
      .pad_oe (pad_oe [g*LPG +: LPG]),
      .alt_in (alt_in [g*LPG +: LPG])
    );
  end

  // read mux over pad levels
  always_comb begin
    rd_byte = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (hit_grp == GRP_W'(g)) rd_byte = pad_in[g*LPG +: LPG];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_hit   <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_hit   <= (io_rd | io_wr) & in_win;
      io_rdata <= rd_hit ? rd_byte : '0;
    end
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int ADDR_W     = 16,
  parameter int NUM_GROUPS = 8,
  parameter int GRP_W      = 3,
  parameter int NL         = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_rd,
  input logic             io_wr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             io_hit,
  input logic [NL-1:0]    cfg_oe,
  input logic [NL-1:0]    pad_out,
  input logic [NL-1:0]    pad_oe,
  input logic [NL-1:0]    alt_in,
  input logic             wr_hit,
  input logic             rd_hit,
  input logic [GRP_W-1:0] hit_grp
);
  logic             q_wr;
  logic [GRP_W-1:0] q_grp;
  logic [7:0]       q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wr   <= 1'b0;
      q_grp  <= '0;
      q_data <= '0;
    end else begin
      q_wr   <= wr_hit;
      q_grp  <= hit_grp;
      q_data <= io_wdata;
    end
  end

  p_no_hit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd | io_wr) |=> !io_hit);

  p_hit_follows_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit | wr_hit) |=> io_hit);

  p_rdata_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (io_rdata == '0));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(pad_out));

  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr |-> (pad_out[int'(q_grp)*8 +: 8] == q_data));

  p_oe_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~cfg_oe) == '0);

  p_alt_off_when_driving_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_in & pad_oe) == '0);
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_GROUPS(NUM_GROUPS),
  .GRP_W     (GRP_W),
  .NL        (NL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_rd   (io_rd),
  .io_wr   (io_wr),
  .io_wdata(io_wdata),
  .io_rdata(io_rdata),
  .io_hit  (io_hit),
  .cfg_oe  (cfg_oe),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .alt_in  (alt_in),
  .wr_hit  (wr_hit),
  .rd_hit  (rd_hit),
  .hit_grp (hit_grp)
);

// File: tb/gpio_port_bank_tb.sv
`timescale 1ns/1ps
module gpio_port_bank_tb;
  localparam int AW = 16;
  localparam int NG = 8;
  localparam int SG = 5;
  localparam int NL = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] io_addr = '0;
  logic          io_rd = 1'b0;
  logic          io_wr = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic          io_hit;
  logic [AW-1:0] cfg_base = '0;
  logic [NL-1:0] cfg_oe = '0;
  logic [NL-1:0] cfg_sel = '0;
  logic [NL-1:0] ext = '0;
  logic [NL-1:0] pad_in;
  logic [NL-1:0] pad_out;
  logic [NL-1:0] pad_oe;
  logic [NL-1:0] alt_in;

  always #4 clk = ~clk;

  // board model: a driven pad reads back its driven value
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port_bank #(.ADDR_W(AW), .NUM_GROUPS(NG), .SIMPLE_GROUPS(SG)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
    .cfg_base(cfg_base), .cfg_oe(cfg_oe), .cfg_sel(cfg_sel), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_in(alt_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [NL-1:0] m_lat = '0;
  logic          m_hit = 1'b0;
  logic [7:0]    m_rdata = '0;

  function automatic logic [NL-1:0] m_mode();
    logic [NL-1:0] v;
    for (int n = 0; n < NL; n++) v[n] = (n / 8 >= SG) ? 1'b1 : cfg_sel[n];
    return v;
  endfunction

  function automatic logic [NL-1:0] m_pads();
    logic [NL-1:0] oe;
    oe = cfg_oe & m_mode();
    return (oe & m_lat) | (~oe & ext);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = '0; m_hit = 1'b0; m_rdata = '0;
    end else begin
      int off;
      logic [NL-1:0] pv;
      off = (int'(io_addr) - int'(cfg_base)) & ((1 << AW) - 1);
      pv = m_pads();
      m_hit = (io_rd || io_wr) && off < NG;
      m_rdata = (io_rd && off < NG) ? pv[off*8 +: 8] : 8'h00;
      if (io_wr && off < NG) m_lat[off*8 +: 8] = io_wdata;
    end
  end

  bit run_cmp = 1'b0;
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      logic [NL-1:0] md;
      md = m_mode();
      check(io_hit == m_hit, "R2 io_hit", 64'(io_hit), 64'(m_hit));
      check(io_rdata == m_rdata, "R3/R9 io_rdata", 64'(io_rdata), 64'(m_rdata));
      check(pad_out == m_lat, "R4 pad_out", pad_out, m_lat);
      check(pad_oe == (cfg_oe & md), "R5 pad_oe", pad_oe, cfg_oe & md);
      check(alt_in == (pad_in & ~md), "R6 alt_in", alt_in, pad_in & ~md);
    end
  end

  task automatic access(input logic [AW-1:0] a, input bit rd, input bit wr,
                        input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    @(posedge clk); #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pad_out == '0, "R7 latches", pad_out, 64'd0);
    check(io_hit == 1'b0, "R7 hit", 64'(io_hit), 64'd0);
    check(io_rdata == 8'h00, "R7 rdata", 64'(io_rdata), 64'd0);
    cfg_base = 16'h0A00;
    ext = 64'hA5C3_0F1E_7788_9921;
    @(posedge clk); #1 rst_n = 1'b1;
    run_cmp = 1'b1;

    // plain writes and reads to every group
    for (int g = 0; g < NG; g++) access(16'h0A00 + 16'(g), 1'b0, 1'b1, 8'(8'h11 * (g + 1)));
    for (int g = 0; g < NG; g++) access(16'h0A00 + 16'(g), 1'b1, 1'b0, 8'h00);

    // R1: bit 0 of group 3 reaches line 24
    access(16'h0A03, 1'b0, 1'b1, 8'h01);
    @(negedge clk);
    check(pad_out[24] == 1'b1 && pad_out[31:25] == 7'd0, "R1 line map",
          64'(pad_out[31:24]), 64'h01);

    // R4 misses below and above the window
    access(16'h09FF, 1'b0, 1'b1, 8'hFF);
    access(16'h0A08, 1'b0, 1'b1, 8'hFF);
    @(negedge clk);
    check(pad_out[31:24] == 8'h01, "R4 miss keeps latch", 64'(pad_out[31:24]), 64'h01);

    // R5/R6/R9: enable drivers, select only some low lines
    cfg_oe = 64'hFFFF_FFFF_FFFF_FFFF;
    cfg_sel = 64'h0000_00F0_F0F0_F0F0;
    for (int g = 0; g < NG; g++) access(16'h0A00 + 16'(g), 1'b1, 1'b0, 8'h00);
    access(16'h0A06, 1'b0, 1'b1, 8'h5A);
    access(16'h0A06, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    check(io_rdata == 8'h5A, "R9 driven readback", 64'(io_rdata), 64'h5A);

    // R8: wrapped window at the top of the space
    cfg_base = 16'hFFFC;
    access(16'h0002, 1'b0, 1'b1, 8'hC3);
    access(16'h0002, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    check(io_rdata == 8'hC3, "R8 wrapped base", 64'(io_rdata), 64'hC3);
    access(16'h0004, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    check(io_hit == 1'b0, "R8 offset 8 misses", 64'(io_hit), 64'd0);
    access(16'h0A06, 1'b1, 1'b0, 8'h00);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      io_addr = 16'hFFF8 + 16'($urandom_range(0, 15));
      io_rd = 1'($urandom);
      io_wr = 1'($urandom);
      io_wdata = 8'($urandom);
      if (i % 50 == 0) begin
        cfg_oe = {$urandom, $urandom};
        cfg_sel = {$urandom, $urandom};
        ext = {$urandom, $urandom};
      end
    end
    @(posedge clk); #1; io_rd = 1'b0; io_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule